// File: doc/BRIEF.md
# USB Device Event Flag and Endpoint 0 Control Registers

This block is the small register bank that sits between a CPU and the serial engine of a low-speed USB device. Three events reach it from the engine as one-cycle pulses: end of a packet on the bus, bus activity, and transmit completion on the shared endpoint 1/endpoint 2 path. Each event sets a sticky flag. Software clears a flag by writing 1 to a write-only clear bit in the same register. Each flag has its own interrupt enable, and the enabled flags are ORed into one interrupt request. Bus activity counts as a resume event only while the suspend control bit is set.

The bank also holds the endpoint 0 control register: data toggle, stall, transmit enable, receive enable and a transmit byte count. The count saturates at the largest packet size.

CPU access is byte-wide. A write is a single-cycle strobe. A read is a combinational view of the addressed register.

Register map:
- Address 0, event register. Flags (read-only): bit 0 end-of-packet, bit 1 resume, bit 2 transmit. Enables (read/write): bit 3 end-of-packet, bit 4 transmit. Clear bits (write-only, read 0): bit 5 end-of-packet, bit 6 resume, bit 7 transmit.
- Address 1, endpoint 0 control. Bit 7 toggle, bit 6 stall, bit 5 transmit enable, bit 4 receive enable, bits 3:0 transmit size.
- Address 2, power register. Bit 0 suspend, bit 1 resume interrupt enable. All other bits read 0.
- Address 3 reads 0.

Top module: `usbdev_evt_regs`

## Requirements
- R1: After reset, addresses 0, 1 and 2 read 0x00 and `irq` is low.
- R2: One cycle after an `evt_eop` pulse, bit 0 of address 0 reads 1. Writes to flag bits 0 to 2 do not change the flags.
- R3: Writing 1 to bit 5, bit 6 or bit 7 of address 0 clears the end-of-packet flag, the resume flag or the transmit flag respectively. Writing 0 to these bits does nothing, and they always read 0.
- R4: An `evt_activity` pulse sets the resume flag (bit 1 of address 0) only while suspend (bit 0 of address 2) is 1. While suspend is 0 the pulse has no effect.
- R5: An `evt_tx` pulse sets the shared transmit flag (bit 2 of address 0). Its enable is bit 4 of address 0.
- R6: If a flag's set event and a write of 1 to its clear bit occur in the same cycle, the flag ends up set.
- R7: `irq` is high whenever an enabled flag is set. The enables are: end-of-packet at address 0 bit 3, transmit at address 0 bit 4, resume at address 2 bit 1. `irq` stays high until software clears the flag or the enable.
- R8: Address 1 holds bit 7 toggle, bit 6 stall, bit 5 transmit enable, bit 4 receive enable and bits 3:0 transmit size. It reads back what was written, and each field also appears on its own output port.
- R9: A transmit size above 8 written to address 1 is stored as 8. Values 0 to 8 are stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Combinational read data for `cpu_addr` |
| evt_eop | input | 1 | End-of-packet detected pulse |
| evt_activity | input | 1 | Bus activity pulse |
| evt_tx | input | 1 | Endpoint 1/2 transmit complete pulse |
| irq | output | 1 | Interrupt request |
| suspend_on | output | 1 | Suspend control bit |
| ep0_toggle | output | 1 | Endpoint 0 data toggle |
| ep0_stall | output | 1 | Endpoint 0 stall |
| ep0_tx_en | output | 1 | Endpoint 0 transmit enable |
| ep0_rx_en | output | 1 | Endpoint 0 receive enable |
| ep0_tx_size | output | 4 | Endpoint 0 transmit byte count |

## Verification
The assertions assume the event inputs and CPU strobes are synchronous to `clk` and last one cycle. They also assume that only a write to address 0 or address 2 can lower a flag or an enable. The `irq` hold property depends on that. The bench changes every input at the falling edge and holds each pulse for exactly one cycle. Reads are sampled two nanoseconds after that edge, when the combinational read path has settled.

// File: rtl/usbdev_evt_regs.sv
module usbdev_evt_regs #(
  parameter int ADDR_W      = 2,
  parameter int MAX_TX_SIZE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              evt_eop,
  input  logic              evt_activity,
  input  logic              evt_tx,
  output logic              irq,
  output logic              suspend_on,
  output logic              ep0_toggle,
  output logic              ep0_stall,
  output logic              ep0_tx_en,
  output logic              ep0_rx_en,
  output logic [3:0]        ep0_tx_size
);
  localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EP0 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PWR = ADDR_W'(2);
  localparam logic [3:0]        SIZE_CAP = 4'(MAX_TX_SIZE);

  logic eop_flag, resume_flag, tx_flag;
  logic eop_ie, tx_ie, resume_ie;

  wire wr_evt = cpu_wr && cpu_addr == A_EVT;
  wire wr_ep0 = cpu_wr && cpu_addr == A_EP0;
  wire wr_pwr = cpu_wr && cpu_addr == A_PWR;

  wire clr_eop    = wr_evt && cpu_wdata[5];
  wire clr_resume = wr_evt && cpu_wdata[6];
  wire clr_tx     = wr_evt && cpu_wdata[7];
  wire set_resume = evt_activity && suspend_on;

  wire [3:0] size_in = (cpu_wdata[3:0] > SIZE_CAP) ? SIZE_CAP : cpu_wdata[3:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eop_flag    <= 1'b0;
      resume_flag <= 1'b0;
      tx_flag     <= 1'b0;
      eop_ie      <= 1'b0;
      tx_ie       <= 1'b0;
      resume_ie   <= 1'b0;
      suspend_on  <= 1'b0;
      ep0_toggle  <= 1'b0;
      ep0_stall   <= 1'b0;
      ep0_tx_en   <= 1'b0;
      ep0_rx_en   <= 1'b0;
      ep0_tx_size <= 4'd0;
    end else begin
      eop_flag    <= evt_eop    | (eop_flag    & ~clr_eop);
      resume_flag <= set_resume | (resume_flag & ~clr_resume);
      tx_flag     <= evt_tx     | (tx_flag     & ~clr_tx);
      if (wr_evt) begin
        eop_ie <= cpu_wdata[3];
        tx_ie  <= cpu_wdata[4];
      end
      if (wr_pwr) begin
        suspend_on <= cpu_wdata[0];
        resume_ie  <= cpu_wdata[1];
      end
      if (wr_ep0) begin
        ep0_toggle  <= cpu_wdata[7];
        ep0_stall   <= cpu_wdata[6];
        ep0_tx_en   <= cpu_wdata[5];
        ep0_rx_en   <= cpu_wdata[4];
        ep0_tx_size <= size_in;
      end
    end
  end

  assign irq = (eop_flag & eop_ie) | (tx_flag & tx_ie) | (resume_flag & resume_ie);

  always_comb begin
    case (cpu_addr)
      A_EVT:   cpu_rdata = {3'b000, tx_ie, eop_ie, tx_flag, resume_flag, eop_flag};
      A_EP0:   cpu_rdata = {ep0_toggle, ep0_stall, ep0_tx_en, ep0_rx_en, ep0_tx_size};
      A_PWR:   cpu_rdata = {6'd0, resume_ie, suspend_on};
      default: cpu_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/usbdev_evt_regs_chk.sv
module usbdev_evt_regs_chk #(
  parameter int ADDR_W      = 2,
  parameter int MAX_TX_SIZE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_wr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              evt_eop,
  input logic              evt_activity,
  input logic              evt_tx,
  input logic              eop_flag,
  input logic              resume_flag,
  input logic              tx_flag,
  input logic              suspend_on,
  input logic              irq,
  input logic [3:0]        ep0_tx_size
);
  wire wr0 = cpu_wr && cpu_addr == '0;
  wire wr2 = cpu_wr && cpu_addr == ADDR_W'(2);

  p_eop_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_eop |=> eop_flag);

  p_eop_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && cpu_wdata[5] && !evt_eop) |=> !eop_flag);

  p_resume_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_activity && !suspend_on && !resume_flag) |=> !resume_flag);

  p_tx_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_tx && wr0 && cpu_wdata[7]) |=> tx_flag);

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr0 && !wr2) |=> irq);

  p_size_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ep0_tx_size <= 4'(MAX_TX_SIZE));
endmodule

bind usbdev_evt_regs usbdev_evt_regs_chk #(.ADDR_W(ADDR_W), .MAX_TX_SIZE(MAX_TX_SIZE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .evt_eop(evt_eop), .evt_activity(evt_activity), .evt_tx(evt_tx),
  .eop_flag(eop_flag), .resume_flag(resume_flag), .tx_flag(tx_flag),
  .suspend_on(suspend_on), .irq(irq), .ep0_tx_size(ep0_tx_size)
);

// File: tb/usbdev_evt_regs_test.sv
`timescale 1ns/1ps
module usbdev_evt_regs_test;
  logic clk = 1'b0, rst_n = 1'b0, cpu_wr = 1'b0;
  logic [1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic evt_eop = 1'b0, evt_activity = 1'b0, evt_tx = 1'b0;
  logic irq, suspend_on, ep0_toggle, ep0_stall, ep0_tx_en, ep0_rx_en;
  logic [3:0] ep0_tx_size;

  always #10 clk = ~clk;

  usbdev_evt_regs uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .evt_eop(evt_eop), .evt_activity(evt_activity), .evt_tx(evt_tx),
    .irq(irq), .suspend_on(suspend_on), .ep0_toggle(ep0_toggle), .ep0_stall(ep0_stall),
    .ep0_tx_en(ep0_tx_en), .ep0_rx_en(ep0_rx_en), .ep0_tx_size(ep0_tx_size)
  );

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  bit mon_go = 1'b0, done = 1'b0;

  initial forever begin
    @(negedge clk);
    #2;
    if (mon_go && q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = it.is_irq ? {7'd0, irq} : cpu_rdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    cpu_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    mon_go = 1'b1;
    @(negedge clk);
    mon_go = 1'b0;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
    q.push_back(it);
    mon_go = 1'b1;
    @(negedge clk);
    mon_go = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [2:0] ev);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    evt_eop = ev[0]; evt_activity = ev[1]; evt_tx = ev[2];
    @(negedge clk);
    cpu_wr = 1'b0; evt_eop = 1'b0; evt_activity = 1'b0; evt_tx = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] ev);
    @(negedge clk);
    evt_eop = ev[0]; evt_activity = ev[1]; evt_tx = ev[2];
    @(negedge clk);
    evt_eop = 1'b0; evt_activity = 1'b0; evt_tx = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_reg(2'd0, 8'h00, "R1 event reg after reset");
    expect_reg(2'd1, 8'h00, "R1 ep0 reg after reset");
    expect_reg(2'd2, 8'h00, "R1 power reg after reset");
    expect_irq(1'b0, "R1 irq after reset");

    pulse(3'b001);
    expect_reg(2'd0, 8'h01, "R2 eop flag set");
    expect_irq(1'b0, "R7 irq off without enable");
    wr(2'd0, 8'h07, 3'b000);
    expect_reg(2'd0, 8'h01, "R2 flag bits read-only");
    wr(2'd0, 8'h00, 3'b000);
    expect_reg(2'd0, 8'h01, "R3 zero to clear bit no effect");

    wr(2'd0, 8'h08, 3'b000);
    expect_reg(2'd0, 8'h09, "R7 eop enable readback");
    expect_irq(1'b1, "R7 irq raised");
    expect_irq(1'b1, "R7 irq held");
    wr(2'd0, 8'h28, 3'b000);
    expect_reg(2'd0, 8'h08, "R3 eop cleared, clear bit reads 0");
    expect_irq(1'b0, "R7 irq dropped");

    pulse(3'b010);
    expect_reg(2'd0, 8'h08, "R4 activity ignored without suspend");
    wr(2'd2, 8'h01, 3'b000);
    expect_reg(2'd2, 8'h01, "R4 suspend set");
    pulse(3'b010);
    expect_reg(2'd0, 8'h0A, "R4 resume flag set in suspend");
    expect_irq(1'b0, "R7 resume not enabled");
    wr(2'd2, 8'h03, 3'b000);
    expect_irq(1'b1, "R7 resume irq");
    wr(2'd0, 8'h48, 3'b000);
    expect_reg(2'd0, 8'h08, "R3 resume cleared");
    expect_irq(1'b0, "R7 resume irq dropped");

    pulse(3'b100);
    expect_reg(2'd0, 8'h0C, "R5 tx flag set");
    wr(2'd0, 8'h18, 3'b000);
    expect_reg(2'd0, 8'h1C, "R5 tx enable readback");
    expect_irq(1'b1, "R5 tx irq");
    wr(2'd0, 8'h98, 3'b000);
    expect_reg(2'd0, 8'h18, "R3 tx cleared");
    expect_irq(1'b0, "R5 tx irq dropped");

    wr(2'd0, 8'h38, 3'b001);
    expect_reg(2'd0, 8'h19, "R6 eop set wins over clear");
    wr(2'd0, 8'h98, 3'b100);
    expect_reg(2'd0, 8'h1D, "R6 tx set wins over clear");
    wr(2'd0, 8'hB8, 3'b000);
    expect_reg(2'd0, 8'h18, "R3 both cleared");

    wr(2'd1, 8'hF5, 3'b000);
    expect_reg(2'd1, 8'hF5, "R8 ep0 readback");
    @(negedge clk);
    checks++;
    if ({ep0_toggle, ep0_stall, ep0_tx_en, ep0_rx_en, ep0_tx_size} !== 8'hF5) begin
      fails++;
      $display("FAIL R8 ep0 ports actual=%02h expected=f5",
               {ep0_toggle, ep0_stall, ep0_tx_en, ep0_rx_en, ep0_tx_size});
    end
    wr(2'd1, 8'hA0, 3'b000);
    expect_reg(2'd1, 8'hA0, "R8 ep0 second pattern");
    wr(2'd1, 8'h0F, 3'b000);
    expect_reg(2'd1, 8'h08, "R9 size 15 saturates");
    wr(2'd1, 8'h49, 3'b000);
    expect_reg(2'd1, 8'h48, "R9 size 9 saturates");
    wr(2'd1, 8'h08, 3'b000);
    expect_reg(2'd1, 8'h08, "R9 size 8 kept");
    wr(2'd1, 8'h07, 3'b000);
    expect_reg(2'd1, 8'h07, "R9 size 7 kept");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule